// File: doc/BRIEF.md
# Bitmap and Message Display Scanner

This block turns a small shared memory into a continuous pixel stream for a 16x16 matrix display. In its normal view it reads a one-bit-per-pixel bitmap and lays two single-pixel colored cursors on top of it, a pink one and a green one. The memory holds only the position of each cursor, and each cursor can be hidden on its own. The block reads the memory through a synchronous read port. It presents one address per clock and uses the returned byte one cycle later.

A one-cycle trigger pulse, together with a 3-bit index, switches the display to one of eight four-character text messages. The messages are drawn from a 3x5 glyph set that covers digits and capital letters. The message stays up for half a second, timed by a cycle counter derived from the clock-frequency parameter. The normal view then comes back without further action. The view is chosen once per frame, so a frame never mixes the two views.

Top module: `display_scanner`

## Requirements
- R1: During reset `pix_valid` is low. After reset the block repeats a 260-cycle frame: 4 cycles with `pix_valid` low, then the 256 pixels with `pix_valid` high, one per clock, in row-major order (x runs 0 to 15 inside each row, rows y from 0 to 15).
- R2: In the normal view, pixel (x,y) takes bit 7-(x mod 8) of the byte at address 0xC0 + 2y + x/8. A set bit gives code 1 (white) and a clear bit gives code 0 (black).
- R3: The cursor bytes are 0xB0 (pink x), 0xB1 (pink y), 0xB2 (green x) and 0xB3 (green y). The position is held in bits 3:0. Bit 7 of an x byte hides that cursor, and bits 6:4 of the x byte have no effect.
- R4: A visible green cursor gives code 3 at its pixel and wins over pink. A visible pink cursor gives code 2 and wins over the bitmap.
- R5: A `msg_go` pulse starts a hold of CLK_HZ/2 cycles. Every frame whose 4-cycle lead-in begins while the hold runs shows the message. With a hold of 4 frames (CLK_HZ = 2080), exactly 4 frames show the message, and the normal view follows.
- R6: Message k uses character bytes 0xE0 + 4k + c for c = 0..3. Character c occupies columns 4c to 4c+2 on rows 5 to 9. Column 4c+3 and all other rows are black. The cursors are not drawn, and only codes 0 and 1 appear.
- R7: Codes 0x30 to 0x39 are digits and codes 0x41 to 0x5A are capital letters. Any other code draws blank. Glyph rows, listed top to bottom with the left column first: 'H' = 101,101,111,101,101; 'I' = 111,010,010,010,111; '1' = 010,110,010,010,111.
- R8: A `msg_go` pulse during a message restarts the full hold and takes the new `msg_sel` index.
- R9: The view and the message index change only between frames. Every frame is either a complete normal view or a complete message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Read address to the shared memory |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| msg_go | input | 1 | One-cycle pulse that starts a message |
| msg_sel | input | 3 | Index of the message to show |
| pix_valid | output | 1 | Pixel output is valid |
| pix_x | output | 4 | Column of the pixel |
| pix_y | output | 4 | Row of the pixel |
| pix_color | output | 2 | 0 black, 1 white, 2 pink, 3 green |

## Verification
The bench drives random bitmaps together with random cursor bytes, some with the hide bit set and some with junk in the unused position bits. These frames separate bit order and byte selection errors from cursor decoding errors. Directed frames then place both cursors on one pixel, hide each cursor in turn, and put the cursors on the corner pixels, which checks the priority order and the hide bit. Message runs are started right after a frame ends, so the number of message frames is fixed, and this shows the exact hold length, the return to the normal view and the index taken on a restart. The message contents mix supported glyphs with unsupported codes, so the glyph shapes, the character placement and the blanking of unknown codes are each checked.

// File: rtl/dsc_pkg.sv
// Shared constants and types of the display scanner.
// Assumes a 16x16 screen, 8-bit memory addresses and two single-pixel cursors.
package dsc_pkg;
    localparam int SCR_DIM       = 16;
    localparam int CRD_W         = $clog2(SCR_DIM);
    localparam int SPR_BYTES     = 4;
    localparam int SPR_COUNT     = SPR_BYTES / 2;
    localparam int PIX_PER_FRAME = SCR_DIM * SCR_DIM;
    localparam int FRAME_LEN     = SPR_BYTES + PIX_PER_FRAME;
    localparam int PH_W          = $clog2(FRAME_LEN);
    localparam int GLYPH_W       = 3;
    localparam int GLYPH_H       = 5;
    localparam int MSG_COUNT     = 8;
    localparam int IDX_W         = $clog2(MSG_COUNT);

    typedef enum logic [1:0] {
        PIX_BLACK = 2'd0,
        PIX_WHITE = 2'd1,
        PIX_PINK  = 2'd2,
        PIX_GREEN = 2'd3
    } pix_code_t;

    // Describes the memory read issued one cycle earlier.
    typedef struct packed {
        logic             vld;
        logic             spr;
        logic [1:0]       sel;
        logic             msg;
        logic [CRD_W-1:0] x;
        logic [CRD_W-1:0] y;
    } scan_tag_t;
endpackage

// File: rtl/dsc_msg_timer.sv
// Message hold timer. A go pulse loads the hold count and latches the index.
// The message stays active while the count is nonzero. Assumes HOLD_CYC >= 1.
module dsc_msg_timer
    import dsc_pkg::*;
#(
    parameter int HOLD_CYC = 50_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [IDX_W-1:0] go_idx,
    output logic             active,
    output logic [IDX_W-1:0] cur_idx
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    logic [CNT_W-1:0] remain_q;

    // Load on a trigger (restarting any running hold), otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            cur_idx  <= '0;
        end else if (go) begin
            remain_q <= CNT_W'(HOLD_CYC);
            cur_idx  <= go_idx;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign active = (remain_q != '0);
endmodule

// File: rtl/dsc_scan_seq.sv
// Frame sequencer. It walks a 260-phase frame: four cursor-byte reads, then
// one read per pixel. It latches the view and the message index once per
// frame, forms the memory address, and registers a tag for the returning data.
// Assumes a memory with one cycle of read latency.
module dsc_scan_seq
    import dsc_pkg::*;
#(
    parameter logic [7:0] BMP_BASE = 8'hC0,
    parameter logic [7:0] SPR_BASE = 8'hB0,
    parameter logic [7:0] MSG_BASE = 8'hE0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_active,
    input  logic [IDX_W-1:0] msg_idx,
    output logic [7:0]       mem_addr,
    output scan_tag_t        tag_q
);
    logic [PH_W-1:0]  ph_q;
    logic             frame_msg_q;
    logic [IDX_W-1:0] frame_idx_q;
    logic             in_spr;
    logic [7:0]       pix_n;
    logic [CRD_W-1:0] cur_x;
    logic [CRD_W-1:0] cur_y;

    assign in_spr = (ph_q < PH_W'(SPR_BYTES));
    assign pix_n  = 8'(ph_q - PH_W'(SPR_BYTES));
    assign cur_x  = pix_n[CRD_W-1:0];
    assign cur_y  = pix_n[2*CRD_W-1:CRD_W];

    // Phase counter, wrapping at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= '0;
        else if (ph_q == PH_W'(FRAME_LEN - 1))
            ph_q <= '0;
        else
            ph_q <= ph_q + 1'b1;
    end

    // Sample the view and the index in phase 0 so they hold for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_msg_q <= 1'b0;
            frame_idx_q <= '0;
        end else if (ph_q == '0) begin
            frame_msg_q <= msg_active;
            frame_idx_q <= msg_idx;
        end
    end

    // Address of the byte this phase needs.
    always_comb begin
        if (in_spr)
            mem_addr = SPR_BASE + 8'(ph_q[1:0]);
        else if (frame_msg_q)
            mem_addr = MSG_BASE + 8'({frame_idx_q, cur_x[CRD_W-1:2]});
        else
            mem_addr = BMP_BASE + 8'({cur_y, cur_x[CRD_W-1]});
    end

    // Tag that travels with the read, so the returned byte can be decoded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag_q <= '0;
        else
            tag_q <= '{vld: 1'b1, spr: in_spr, sel: ph_q[1:0],
                       msg: frame_msg_q, x: cur_x, y: cur_y};
    end
endmodule

// File: rtl/dsc_glyph_rom.sv
// 3x5 glyph lookup for digits (0x30-0x39) and capital letters (0x41-0x5A).
// Any other code is blank. Bit 14 is the top-left dot; the order is row-major.
module dsc_glyph_rom
    import dsc_pkg::*;
(
    input  logic [7:0] code,
    input  logic [2:0] row,
    input  logic [1:0] col,
    output logic       lit
);
    logic [15:0] shape;
    logic [3:0]  bit_idx;

    // Shape table. Each group of three bits is one row, left column first.
    always_comb begin
        case (code)
            8'h30: shape = 16'b0_111_101_101_101_111;
            8'h31: shape = 16'b0_010_110_010_010_111;
            8'h32: shape = 16'b0_111_001_111_100_111;
            8'h33: shape = 16'b0_111_001_111_001_111;
            8'h34: shape = 16'b0_101_101_111_001_001;
            8'h35: shape = 16'b0_111_100_111_001_111;
            8'h36: shape = 16'b0_111_100_111_101_111;
            8'h37: shape = 16'b0_111_001_001_001_001;
            8'h38: shape = 16'b0_111_101_111_101_111;
            8'h39: shape = 16'b0_111_101_111_001_111;
            8'h41: shape = 16'b0_010_101_111_101_101;
            8'h42: shape = 16'b0_110_101_110_101_110;
            8'h43: shape = 16'b0_011_100_100_100_011;
            8'h44: shape = 16'b0_110_101_101_101_110;
            8'h45: shape = 16'b0_111_100_110_100_111;
            8'h46: shape = 16'b0_111_100_110_100_100;
            8'h47: shape = 16'b0_011_100_101_101_011;
            8'h48: shape = 16'b0_101_101_111_101_101;
            8'h49: shape = 16'b0_111_010_010_010_111;
            8'h4A: shape = 16'b0_001_001_001_101_010;
            8'h4B: shape = 16'b0_101_101_110_101_101;
            8'h4C: shape = 16'b0_100_100_100_100_111;
            8'h4D: shape = 16'b0_101_111_111_101_101;
            8'h4E: shape = 16'b0_110_101_101_101_101;
            8'h4F: shape = 16'b0_010_101_101_101_010;
            8'h50: shape = 16'b0_110_101_110_100_100;
            8'h51: shape = 16'b0_010_101_101_110_011;
            8'h52: shape = 16'b0_110_101_110_101_101;
            8'h53: shape = 16'b0_011_100_010_001_110;
            8'h54: shape = 16'b0_111_010_010_010_010;
            8'h55: shape = 16'b0_101_101_101_101_111;
            8'h56: shape = 16'b0_101_101_101_101_010;
            8'h57: shape = 16'b0_101_101_111_111_101;
            8'h58: shape = 16'b0_101_101_010_101_101;
            8'h59: shape = 16'b0_101_101_010_010_010;
            8'h5A: shape = 16'b0_111_001_010_100_111;
            default: shape = '0;
        endcase
    end

    // Pick one dot. Positions outside the 3x5 cell are dark.
    always_comb begin
        bit_idx = 4'(4'd14 - (4'(row) * 4'd3 + 4'(col)));
        if (row < 3'(GLYPH_H) && col < 2'(GLYPH_W))
            lit = shape[bit_idx];
        else
            lit = 1'b0;
    end
endmodule

// File: rtl/dsc_pix_resolve.sv
// Pixel resolver. It captures the cursor bytes, decodes each returned byte by
// its tag into a color code, and registers the pixel outputs.
// Assumes the tag arrives in the same cycle as the byte it describes.
module dsc_pix_resolve
    import dsc_pkg::*;
#(
    parameter int TEXT_TOP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scan_tag_t        tag_q,
    input  logic [7:0]       mem_rdata,
    output logic             pix_valid,
    output logic [CRD_W-1:0] pix_x,
    output logic [CRD_W-1:0] pix_y,
    output logic [1:0]       pix_color,
    output logic             pix_is_msg
);
    logic [CRD_W-1:0] pos_q [SPR_BYTES];
    logic [SPR_COUNT-1:0] hide_q;
    logic [SPR_COUNT-1:0] spr_hit;
    logic [CRD_W-1:0] trow;
    logic             in_band;
    logic             glyph_lit;
    logic             bmp_bit;
    pix_code_t        nxt_color;

    // Keep the position nibbles and the hide flags from the cursor reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SPR_BYTES; i++) pos_q[i] <= '0;
            hide_q <= '0;
        end else if (tag_q.vld && tag_q.spr) begin
            pos_q[tag_q.sel] <= mem_rdata[CRD_W-1:0];
            if (!tag_q.sel[0]) hide_q[tag_q.sel[1]] <= mem_rdata[7];
        end
    end

    // One position compare per cursor: index 0 is pink, index 1 is green.
    for (genvar s = 0; s < SPR_COUNT; s++) begin : g_spr
        assign spr_hit[s] = !hide_q[s] && (pos_q[2*s] == tag_q.x)
                            && (pos_q[2*s+1] == tag_q.y);
    end

    assign bmp_bit = mem_rdata[~tag_q.x[2:0]];
    assign trow    = tag_q.y - CRD_W'(TEXT_TOP);
    assign in_band = (tag_q.y >= CRD_W'(TEXT_TOP)) && (trow < CRD_W'(GLYPH_H));

    dsc_glyph_rom u_font (
        .code (mem_rdata),
        .row  (trow[2:0]),
        .col  (tag_q.x[1:0]),
        .lit  (glyph_lit)
    );

    // Color choice: text in a message frame, else green, then pink, then bitmap.
    always_comb begin
        if (tag_q.msg)
            nxt_color = (in_band && glyph_lit) ? PIX_WHITE : PIX_BLACK;
        else if (spr_hit[1])
            nxt_color = PIX_GREEN;
        else if (spr_hit[0])
            nxt_color = PIX_PINK;
        else
            nxt_color = bmp_bit ? PIX_WHITE : PIX_BLACK;
    end

    // Output register for the pixel stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid  <= 1'b0;
            pix_x      <= '0;
            pix_y      <= '0;
            pix_color  <= 2'd0;
            pix_is_msg <= 1'b0;
        end else begin
            pix_valid  <= tag_q.vld && !tag_q.spr;
            pix_x      <= tag_q.x;
            pix_y      <= tag_q.y;
            pix_color  <= nxt_color;
            pix_is_msg <= tag_q.msg;
        end
    end
endmodule

// File: rtl/display_scanner.sv
// Top of the display scanner. It joins the message timer, the frame
// sequencer and the pixel resolver. Assumes the memory layout given in the
// brief and a memory with one cycle of read latency.
module display_scanner
    import dsc_pkg::*;
#(
    parameter int         CLK_HZ   = 100_000_000,
    parameter logic [7:0] BMP_BASE = 8'hC0,
    parameter logic [7:0] SPR_BASE = 8'hB0,
    parameter logic [7:0] MSG_BASE = 8'hE0,
    parameter int         TEXT_TOP = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] mem_addr,
    input  logic [7:0] mem_rdata,
    input  logic       msg_go,
    input  logic [2:0] msg_sel,
    output logic       pix_valid,
    output logic [3:0] pix_x,
    output logic [3:0] pix_y,
    output logic [1:0] pix_color
);
    localparam int HOLD_CYC = CLK_HZ / 2;

    logic             msg_active;
    logic [IDX_W-1:0] msg_idx;
    scan_tag_t        tag_q;
    logic             pix_is_msg;

    dsc_msg_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (msg_go),
        .go_idx  (msg_sel),
        .active  (msg_active),
        .cur_idx (msg_idx)
    );

    dsc_scan_seq #(
        .BMP_BASE (BMP_BASE),
        .SPR_BASE (SPR_BASE),
        .MSG_BASE (MSG_BASE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_active (msg_active),
        .msg_idx    (msg_idx),
        .mem_addr   (mem_addr),
        .tag_q      (tag_q)
    );

    dsc_pix_resolve #(.TEXT_TOP(TEXT_TOP)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .tag_q      (tag_q),
        .mem_rdata  (mem_rdata),
        .pix_valid  (pix_valid),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .pix_color  (pix_color),
        .pix_is_msg (pix_is_msg)
    );
endmodule

// File: rtl/dsc_checker.sv
// Temporal checks on the display scanner, attached to every instance by bind.
module dsc_checker #(
    parameter logic [7:0] SPR_BASE = 8'hB0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_valid,
    input logic [3:0] pix_x,
    input logic [3:0] pix_y,
    input logic [1:0] pix_color,
    input logic       pix_is_msg,
    input logic       msg_go,
    input logic       msg_active,
    input logic [7:0] mem_addr
);
    // R1: consecutive pixels step x by one.
    p_col_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && $past(pix_valid) |-> pix_x == 4'($past(pix_x) + 4'd1));

    // R1: a new row starts when x wraps to zero.
    p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && $past(pix_valid) && pix_x == 4'd0 |-> pix_y == 4'($past(pix_y) + 4'd1));

    // R1: the last pixel of a frame is followed by the lead-in gap.
    p_frame_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_x == 4'd15 && pix_y == 4'd15 |=> !pix_valid);

    // R2: every read falls in the display region of memory.
    p_addr_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr >= SPR_BASE);

    // R5: a trigger starts the hold.
    p_hold_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_go |=> msg_active);

    // R5: without a trigger an idle timer stays idle.
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_active && !msg_go |=> !msg_active);

    // R6: message frames carry only black and white.
    p_msg_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_is_msg |-> !pix_color[1]);

    // R9: the view cannot change inside a frame.
    p_view_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && $past(pix_valid) |-> pix_is_msg == $past(pix_is_msg));
endmodule

bind display_scanner dsc_checker #(.SPR_BASE(SPR_BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .pix_color  (pix_color),
    .pix_is_msg (pix_is_msg),
    .msg_go     (msg_go),
    .msg_active (msg_active),
    .mem_addr   (mem_addr)
);

// File: tb/test_display_scanner.sv
// Bench for display_scanner: random and directed frames plus message runs.
module test_display_scanner;
    localparam int CLK_HZ = 2080;   // hold = 1040 cycles = 4 frames

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00;
    logic       msg_go = 1'b0;
    logic [2:0] msg_sel = 3'd0;
    logic       pix_valid;
    logic [3:0] pix_x, pix_y;
    logic [1:0] pix_color;

    logic [7:0] mem [256];
    logic [1:0] cap [16][16];
    int n_chk = 0;
    int n_err = 0;
    int seq [8];

    always #5 clk = ~clk;

    // Synchronous memory with one cycle of latency.
    always @(posedge clk) mem_rdata <= mem[mem_addr];

    display_scanner #(.CLK_HZ(CLK_HZ)) i_display_scanner (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .msg_go(msg_go), .msg_sel(msg_sel), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color)
    );

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic logic [2:0] font_row(logic [7:0] code, int r);
        logic [14:0] g;
        case (code)
            8'h48: g = 15'b101_101_111_101_101;   // 'H'
            8'h49: g = 15'b111_010_010_010_111;   // 'I'
            8'h31: g = 15'b010_110_010_010_111;   // '1'
            default: g = '0;
        endcase
        return g[14 - 3*r -: 3];
    endfunction

    function automatic logic [1:0] exp_bmp(int x, int y);
        logic [7:0] b, pxb, pyb, gxb, gyb;
        b   = mem[8'(192 + 2*y + x/8)];
        pxb = mem[8'hB0]; pyb = mem[8'hB1];
        gxb = mem[8'hB2]; gyb = mem[8'hB3];
        if (!gxb[7] && int'(gxb[3:0]) == x && int'(gyb[3:0]) == y) return 2'd3;
        if (!pxb[7] && int'(pxb[3:0]) == x && int'(pyb[3:0]) == y) return 2'd2;
        return {1'b0, b[7 - x%8]};
    endfunction

    function automatic logic [1:0] exp_msg(int k, int x, int y);
        logic [2:0] r;
        if (y < 5 || y > 9 || x%4 == 3) return 2'd0;
        r = font_row(mem[8'(224 + 4*k + x/4)], y - 5);
        return {1'b0, r[2 - x%4]};
    endfunction

    // 8 = normal view, 0..7 = message index, -1 = matches nothing.
    function automatic int classify();
        bit ok;
        ok = 1;
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                if (cap[y][x] != exp_bmp(x, y)) ok = 0;
        if (ok) return 8;
        for (int k = 0; k < 8; k++) begin
            ok = 1;
            for (int y = 0; y < 16; y++)
                for (int x = 0; x < 16; x++)
                    if (cap[y][x] != exp_msg(k, x, y)) ok = 0;
            if (ok) return k;
        end
        return -1;
    endfunction

    // Capture one frame from pixel (0,0); check order and validity (R1).
    task automatic capture();
        int bad_i, gx, gy;
        bad_i = -1; gx = 0; gy = 0;
        do @(negedge clk); while (!(pix_valid && pix_x == 4'd0 && pix_y == 4'd0));
        for (int i = 0; i < 256; i++) begin
            if (i > 0) @(negedge clk);
            if (bad_i < 0 && (!pix_valid || pix_x != 4'(i%16) || pix_y != 4'(i/16))) begin
                bad_i = i; gx = pix_x; gy = pix_y;
            end
            cap[i/16][i%16] = pix_color;
        end
        chk(bad_i < 0, $sformatf("R1 scan order at step %0d: got (%0d,%0d) expected (%0d,%0d)",
            bad_i, gx, gy, bad_i%16, bad_i/16));
    endtask

    task automatic check_bmp(input string req);
        int bx, by, got, exp;
        bx = -1; by = 0; got = 0; exp = 0;
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                if (bx < 0 && cap[y][x] != exp_bmp(x, y)) begin
                    bx = x; by = y; got = cap[y][x]; exp = exp_bmp(x, y);
                end
        chk(bx < 0, $sformatf("%s pixel (%0d,%0d): got %0d expected %0d", req, bx, by, got, exp));
    endtask

    // Let one frame pass after a memory change, then check the next one.
    task automatic frame_after_update(input string req);
        capture();
        capture();
        check_bmp(req);
    endtask

    task automatic trigger(input int k);
        @(negedge clk);
        msg_go = 1'b1; msg_sel = 3'(k);
        @(negedge clk);
        msg_go = 1'b0;
    endtask

    task automatic run_frames(input int n);
        for (int i = 0; i < n; i++) begin
            capture();
            seq[i] = classify();
            chk(seq[i] != -1, $sformatf("R9 frame %0d mixed or corrupt: got class %0d expected a whole view",
                i, seq[i]));
        end
    endtask

    function automatic int count_of(int v, int n);
        int c;
        c = 0;
        for (int i = 0; i < n; i++) if (seq[i] == v) c++;
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R1: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        int c;
        seed_v = $urandom(32'h5EED_0042);
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        // Eight distinct messages built from H, I, 1, blank and unsupported codes.
        for (int k = 0; k < 8; k++) begin
            mem[8'(224 + 4*k)]     = k[0] ? 8'h48 : 8'h49;
            mem[8'(224 + 4*k + 1)] = k[1] ? 8'h31 : 8'h20;
            mem[8'(224 + 4*k + 2)] = k[2] ? 8'h49 : 8'h48;
            mem[8'(224 + 4*k + 3)] = k[0] ? 8'h68 : 8'h3A;
        end

        // R1: outputs idle during reset.
        repeat (3) @(negedge clk);
        chk(pix_valid == 1'b0, $sformatf("R1 reset pix_valid: got %0d expected 0", pix_valid));
        rst_n = 1'b1;

        // R2 R3 R4: random bitmaps and random cursor bytes.
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 32; i++) mem[8'(192 + i)] = 8'($urandom);
            for (int s = 0; s < 2; s++) begin
                mem[8'(176 + 2*s)]     = {($urandom % 4 == 0), 3'($urandom), 4'($urandom)};
                mem[8'(176 + 2*s + 1)] = {4'($urandom), 4'($urandom)};
            end
            frame_after_update($sformatf("R2 R3 R4 random round %0d", r));
        end

        // R4: both cursors on one pixel over a full bitmap; green wins.
        for (int i = 0; i < 32; i++) mem[8'(192 + i)] = 8'hFF;
        mem[8'hB0] = 8'h03; mem[8'hB1] = 8'h07; mem[8'hB2] = 8'h03; mem[8'hB3] = 8'h07;
        frame_after_update("R4 overlap");
        chk(cap[7][3] == 2'd3, $sformatf("R4 overlap color: got %0d expected 3", cap[7][3]));

        // R3: pink hidden by bit 7, green visible at the origin.
        for (int i = 0; i < 32; i++) mem[8'(192 + i)] = 8'h00;
        mem[8'hB0] = 8'h85; mem[8'hB1] = 8'h05; mem[8'hB2] = 8'h00; mem[8'hB3] = 8'h00;
        frame_after_update("R3 pink hidden");
        chk(cap[5][5] == 2'd0, $sformatf("R3 hidden pink shows: got %0d expected 0", cap[5][5]));

        // R3 R4: junk in bits 6:4, green hidden, pink in the far corner.
        mem[8'hB0] = 8'h7F; mem[8'hB1] = 8'h0F; mem[8'hB2] = 8'hFF; mem[8'hB3] = 8'h0F;
        frame_after_update("R3 junk bits");
        chk(cap[15][15] == 2'd2, $sformatf("R3 corner pink: got %0d expected 2", cap[15][15]));

        // R2: alternating bytes, both cursors hidden.
        for (int i = 0; i < 32; i++) mem[8'(192 + i)] = i[0] ? 8'h55 : 8'hA5;
        mem[8'hB0] = 8'h80; mem[8'hB2] = 8'h80;
        frame_after_update("R2 pattern");

        // R5 R6 R7: message 5 with a visible cursor in the text band.
        for (int i = 0; i < 32; i++) mem[8'(192 + i)] = 8'($urandom);
        mem[8'hB0] = 8'h04; mem[8'hB1] = 8'h06;
        frame_after_update("R2 before message");
        trigger(5);
        run_frames(7);
        chk(seq[0] == 8, $sformatf("R9 frame in progress at trigger: got %0d expected 8", seq[0]));
        chk(seq[1] == 5, $sformatf("R6 R7 message content: got class %0d expected 5", seq[1]));
        c = count_of(5, 7);
        chk(c == 4, $sformatf("R5 hold length in frames: got %0d expected 4", c));
        chk(seq[5] == 8, $sformatf("R5 return to normal view: got class %0d expected 8", seq[5]));

        // R8: restart with a new index during a running message.
        trigger(2);
        run_frames(2);
        chk(seq[1] == 2, $sformatf("R5 second message: got class %0d expected 2", seq[1]));
        trigger(6);
        run_frames(7);
        chk(seq[0] == 2, $sformatf("R9 frame latched before restart: got %0d expected 2", seq[0]));
        c = count_of(6, 7);
        chk(c == 4, $sformatf("R8 restarted hold in frames: got %0d expected 4", c));
        c = count_of(2, 7);
        chk(c == 1, $sformatf("R8 old index frames after restart: got %0d expected 1", c));
        chk(seq[5] == 8, $sformatf("R8 return after restart: got class %0d expected 8", seq[5]));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule